// File: doc/BRIEF.md
# ECP Host Byte Channel Controller

This block is the host end of a bidirectional parallel byte channel of the extended-capabilities kind. On the cable side it drives a strobe line, an acknowledge/tag line, a channel-active line and an active-low turnaround request. It samples the peripheral's acknowledge/tag, its strobe, its turnaround grant, its data-pending request and a spare flag. It also controls the output enable of an 8-bit data bus. Every handshake is two-phase. The tag line tells a data byte (high) from a command byte (low).

On the system side, a valid/ready port accepts a byte together with its tag for forward transmission. Received bytes come out as a one-cycle valid pulse that carries the byte and its tag. A level input asks for reverse mode. The block leaves forward mode only by releasing the bus and then asking for the turnaround. It returns by withdrawing the request and waiting for the grant to lift. Every cable-side wait is bounded by a programmable cycle count. When the count runs out, the lines go back to forward idle and a one-cycle error pulse is raised.

All peripheral inputs pass through two-flop synchronizers before any decision is taken. The received byte is captured straight from the bus when the synchronized peripheral strobe is seen to rise. The peripheral must hold the byte until the host acknowledge falls.

Top module: `ecp_host_port`

## Requirements
- R1: After reset the lines are: host strobe high, host ack/tag high, active low, turnaround request high (not asserted), bus enable high. `fwd_ready_o` is high when the peripheral ack is low. `rev_valid_o` and `err_o` are low.
- R2: For an accepted forward byte, `pd_o` carries the byte with `pd_oe_o` high, and `host_ack_o` carries the tag (1 = data, 0 = command). Both are set at least one cycle before the host strobe falls, and they stay stable while the strobe is low.
- R3: The host strobe returns high only after the synchronized peripheral ack has been seen high, or after a timeout. At that rising edge `pd_o` still carries the byte.
- R4: No further forward byte is accepted (`fwd_ready_o` low) until the peripheral ack has returned low, and none is accepted while reverse mode is requested.
- R5: `active_o` is high whenever a handshake is in progress, including the whole of reverse mode, and low in forward idle.
- R6: The bus enable drops at least one cycle before the turnaround request goes low, and stays low as long as the request is low.
- R7: No reverse byte is acknowledged or delivered until the turnaround grant has been seen low.
- R8: In reverse mode the host raises `host_ack_o` only after the peripheral strobe is seen low. The tag is the peripheral ack level at that moment (1 = data, 0 = command).
- R9: When the peripheral strobe is seen rising, the bus byte is captured and `rev_valid_o` pulses for one cycle with the byte and tag. `host_ack_o` then drops low.
- R10: When reverse mode is withdrawn, the request goes high first. The bus stays released and no forward byte is accepted until the grant is seen high again.
- R11: If a wait lasts longer than `cfg_timeout_i` cycles, `err_o` pulses for one cycle and the lines return to forward idle (strobe high, request high, active low).
- R12: A `cfg_timeout_i` of zero disables every timeout.
- R13: `periph_req_o` is the synchronized inverse of `periph_req_n_i`, and `xflag_o` is the synchronized `xflag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout_i | input | 16 | Wait limit in cycles, 0 disables |
| rev_mode_i | input | 1 | Level request for reverse mode |
| fwd_valid_i | input | 1 | Forward byte offered |
| fwd_ready_o | output | 1 | Forward byte accepted when valid |
| fwd_byte_i | input | 8 | Forward byte |
| fwd_is_data_i | input | 1 | Forward tag, 1 data, 0 command |
| rev_valid_o | output | 1 | One-cycle pulse with a received byte |
| rev_byte_o | output | 8 | Received byte |
| rev_is_data_o | output | 1 | Received tag, 1 data, 0 command |
| err_o | output | 1 | One-cycle timeout pulse |
| periph_req_o | output | 1 | Synchronized peripheral data-pending |
| xflag_o | output | 1 | Synchronized spare flag |
| host_clk_o | output | 1 | Host strobe |
| host_ack_o | output | 1 | Host ack / forward tag |
| active_o | output | 1 | Channel active |
| rev_req_n_o | output | 1 | Turnaround request, active low |
| periph_ack_i | input | 1 | Peripheral ack / reverse tag |
| periph_clk_i | input | 1 | Peripheral strobe |
| ack_rev_n_i | input | 1 | Turnaround grant, active low |
| periph_req_n_i | input | 1 | Peripheral data pending, active low |
| xflag_i | input | 1 | Spare flag |
| pd_o | output | 8 | Bus drive value |
| pd_i | input | 8 | Bus sampled value |
| pd_oe_o | output | 1 | Bus output enable |

## Verification
Several rules are checked by assertions on every cycle. The bus is never enabled while the turnaround request is low, and it is released before the request falls. The forward byte and tag stay stable while the strobe is low. The strobe rises only after an ack or a timeout. A reverse byte is delivered only inside a granted turnaround. The error pulse is one cycle wide and never fires when timeouts are disabled. Other behaviour can only be shown by the bench scenarios: the byte and tag values across the cable, the refusal of new bytes while the peripheral ack is held, the wait for the grant before reverse data is accepted, the ordered return to forward mode, and the timeout and disable behaviour.

// File: rtl/ecp_host_pkg.sv
// Shared types for the ECP host channel.
// Assumes: one clock domain; cable inputs are synchronized before use.
package ecp_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,      // forward idle, bus driven
        ST_F_SETUP,   // byte and tag presented, strobe still high
        ST_F_STROBE,  // strobe low, waiting for peripheral ack high
        ST_F_RELEASE, // strobe high, waiting for peripheral ack low
        ST_TURN,      // bus released, request not yet asserted
        ST_R_GRANT,   // request low, waiting for grant
        ST_R_WAIT,    // granted, waiting for peripheral strobe low
        ST_R_ACK,     // host ack high, waiting for peripheral strobe high
        ST_R_EXIT     // request high, waiting for grant to lift
    } ecp_state_e;

    // index of each synchronized cable input
    localparam int SY_ACK   = 0;
    localparam int SY_PCLK  = 1;
    localparam int SY_GRANT = 2;
    localparam int SY_REQ   = 3;
    localparam int SY_XFLAG = 4;
    localparam int SY_W     = 5;

endpackage

// File: rtl/ecp_sync.sv
// Two-flop synchronizer bank, one chain per bit.
// Assumes: inputs are level signals slower than two clock cycles.
module ecp_sync #(
    parameter int          W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // two-stage capture of one asynchronous line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end

        assign q_o[g] = sync_q;
    end

endmodule

// File: rtl/ecp_wait_timer.sv
// Cycle counter for one handshake wait; flags expiry past the limit.
// Assumes: clear_i pulses when the controller changes state.
module ecp_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    // count cycles spent in the current wait, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (limit_i != '0) && (cnt_q >= limit_i);

endmodule

// File: rtl/ecp_host_port.sv
// Host end of an ECP-style byte channel: forward and reverse two-phase
// handshakes, bus turnaround by request/grant, per-wait timeouts.
// Assumes: peripheral holds reverse data until host ack falls.
module ecp_host_port
    import ecp_host_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_timeout_i,
    input  logic          rev_mode_i,
    input  logic          fwd_valid_i,
    output logic          fwd_ready_o,
    input  logic [DW-1:0] fwd_byte_i,
    input  logic          fwd_is_data_i,
    output logic          rev_valid_o,
    output logic [DW-1:0] rev_byte_o,
    output logic          rev_is_data_o,
    output logic          err_o,
    output logic          periph_req_o,
    output logic          xflag_o,
    output logic          host_clk_o,
    output logic          host_ack_o,
    output logic          active_o,
    output logic          rev_req_n_o,
    input  logic          periph_ack_i,
    input  logic          periph_clk_i,
    input  logic          ack_rev_n_i,
    input  logic          periph_req_n_i,
    input  logic          xflag_i,
    output logic [DW-1:0] pd_o,
    input  logic [DW-1:0] pd_i,
    output logic          pd_oe_o
);

    localparam logic [SY_W-1:0] SYNC_RST = 5'b01110; // ack0 pclk1 grant1 req1 xflag0

    ecp_state_e    state_q, state_d;
    logic [SY_W-1:0] sy;
    logic          ack_s, pclk_s, grant_n_s;
    logic          in_wait, tmo;
    logic          fwd_take;
    logic [DW-1:0] fbyte_q, rbyte_q;
    logic          ftag_q, rtag_q, rvalid_q, err_q;

    ecp_sync #(.W(SY_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({xflag_i, periph_req_n_i, ack_rev_n_i, periph_clk_i, periph_ack_i}),
        .q_o   (sy)
    );

    assign ack_s        = sy[SY_ACK];
    assign pclk_s       = sy[SY_PCLK];
    assign grant_n_s    = sy[SY_GRANT];
    assign periph_req_o = ~sy[SY_REQ];
    assign xflag_o      = sy[SY_XFLAG];

    // decide which states count as bounded waits
    always_comb begin
        unique case (state_q)
            ST_F_STROBE, ST_F_RELEASE, ST_R_GRANT, ST_R_ACK, ST_R_EXIT: in_wait = 1'b1;
            default: in_wait = 1'b0;
        endcase
    end

    ecp_wait_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_wait),
        .clear_i   (state_d != state_q),
        .limit_i   (cfg_timeout_i),
        .expired_o (tmo)
    );

    assign fwd_ready_o = (state_q == ST_IDLE) && !rev_mode_i && !ack_s;
    assign fwd_take    = fwd_valid_i && fwd_ready_o;

    // next-state decision for both directions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (rev_mode_i) state_d = ST_TURN;
                          else if (fwd_take) state_d = ST_F_SETUP;
            ST_F_SETUP:   state_d = ST_F_STROBE;
            ST_F_STROBE:  if (tmo) state_d = ST_IDLE;
                          else if (ack_s) state_d = ST_F_RELEASE;
            ST_F_RELEASE: if (tmo || !ack_s) state_d = ST_IDLE;
            ST_TURN:      state_d = ST_R_GRANT;
            ST_R_GRANT:   if (tmo) state_d = ST_IDLE;
                          else if (!rev_mode_i) state_d = ST_R_EXIT;
                          else if (!grant_n_s) state_d = ST_R_WAIT;
            ST_R_WAIT:    if (!rev_mode_i) state_d = ST_R_EXIT;
                          else if (!pclk_s) state_d = ST_R_ACK;
            ST_R_ACK:     if (tmo) state_d = ST_IDLE;
                          else if (pclk_s) state_d = ST_R_WAIT;
            ST_R_EXIT:    if (tmo || grant_n_s) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // forward byte and tag holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbyte_q <= '0;
            ftag_q  <= 1'b1;
        end else if (fwd_take && !rev_mode_i) begin
            fbyte_q <= fwd_byte_i;
            ftag_q  <= fwd_is_data_i;
        end
    end

    // reverse tag, byte capture and delivery pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtag_q   <= 1'b0;
            rbyte_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            if (state_q == ST_R_WAIT && state_d == ST_R_ACK) rtag_q <= ack_s;
            if (state_q == ST_R_ACK && !tmo && pclk_s) begin
                rbyte_q  <= pd_i;
                rvalid_q <= 1'b1;
            end
        end
    end

    // timeout error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= tmo;
    end

    // cable line decode from state
    always_comb begin
        host_clk_o  = (state_q != ST_F_STROBE);
        rev_req_n_o = !(state_q inside {ST_R_GRANT, ST_R_WAIT, ST_R_ACK});
        pd_oe_o     = (state_q inside {ST_IDLE, ST_F_SETUP, ST_F_STROBE, ST_F_RELEASE});
        host_ack_o  = pd_oe_o ? ftag_q : (state_q == ST_R_ACK);
        active_o    = (state_q != ST_IDLE);
    end

    assign pd_o          = fbyte_q;
    assign rev_valid_o   = rvalid_q;
    assign rev_byte_o    = rbyte_q;
    assign rev_is_data_o = rtag_q;
    assign err_o         = err_q;

    // ---------------- assertions ----------------
    a_r6_bus_off_in_rev: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_req_n_o |-> !pd_oe_o);

    a_r6_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rev_req_n_o) |-> $past(!pd_oe_o));

    a_r2_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_clk_o) || (!host_clk_o && $past(!host_clk_o))
        |-> ($stable(pd_o) && $stable(host_ack_o) && pd_oe_o));

    a_r3_rise_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_clk_o) |-> ($past(ack_s) || $past(tmo)));

    a_r7_rev_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
        rev_valid_o |-> $past(!rev_req_n_o));

    a_r5_active_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_clk_o || !rev_req_n_o) |-> active_o);

    a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r12_off_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_timeout_i == '0) |-> !err_o);

endmodule

// File: tb/sim_ecp_host_port.sv
module sim_ecp_host_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_timeout;
    logic        rev_mode, fwd_valid, fwd_is_data;
    logic [7:0]  fwd_byte;
    logic        fwd_ready, rev_valid, rev_is_data, err, periph_req, xflag_s;
    logic [7:0]  rev_byte, pd_o, pd_i;
    logic        host_clk, host_ack, active, rev_req_n, pd_oe;
    logic        periph_ack, periph_clk, ack_rev_n, periph_req_n, xflag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ecp_host_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_timeout_i(cfg_timeout), .rev_mode_i(rev_mode),
        .fwd_valid_i(fwd_valid), .fwd_ready_o(fwd_ready), .fwd_byte_i(fwd_byte),
        .fwd_is_data_i(fwd_is_data), .rev_valid_o(rev_valid), .rev_byte_o(rev_byte),
        .rev_is_data_o(rev_is_data), .err_o(err), .periph_req_o(periph_req),
        .xflag_o(xflag_s), .host_clk_o(host_clk), .host_ack_o(host_ack),
        .active_o(active), .rev_req_n_o(rev_req_n), .periph_ack_i(periph_ack),
        .periph_clk_i(periph_clk), .ack_rev_n_i(ack_rev_n),
        .periph_req_n_i(periph_req_n), .xflag_i(xflag), .pd_o(pd_o), .pd_i(pd_i),
        .pd_oe_o(pd_oe)
    );

    // {tag, byte}: tag 1 = data, 0 = command
    localparam logic [8:0] FWD_VEC [6] = '{
        9'h1A5, 9'h03C, 9'h1FF, 9'h000, 9'h15A, 9'h081
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic push_byte(input logic [7:0] b, input logic tag);
        @(negedge clk);
        fwd_byte = b; fwd_is_data = tag; fwd_valid = 1'b1;
        for (int i = 0; i < 200 && !fwd_ready; i++) @(negedge clk);
        @(negedge clk);
        fwd_valid = 1'b0;
    endtask

    // full forward byte with peripheral model (R2 R3 R4)
    task automatic fwd_xfer(input logic [7:0] b, input logic tag);
        logic [7:0] last_pd;
        logic       last_ack, last_oe;
        push_byte(b, tag);
        last_pd = pd_o; last_ack = host_ack; last_oe = pd_oe;
        for (int i = 0; i < 200 && host_clk; i++) begin
            last_pd = pd_o; last_ack = host_ack; last_oe = pd_oe;
            @(negedge clk);
        end
        chk("R2 setup byte", last_pd, b);
        chk("R2 setup tag", last_ack, tag);
        chk("R2 setup oe", last_oe, 1'b1);
        chk("R2 strobe byte", pd_o, b);
        periph_ack = 1'b1;
        for (int i = 0; i < 200 && !host_clk; i++) @(negedge clk);
        chk("R3 byte at rise", pd_o, b);
        fwd_byte = ~b; fwd_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 ready held low", fwd_ready, 1'b0);
        fwd_valid = 1'b0;
        periph_ack = 1'b0;
        for (int i = 0; i < 200 && !fwd_ready; i++) @(negedge clk);
        chk("R4 ready after ack low", fwd_ready, 1'b1);
    endtask

    // one reverse byte, channel already granted (R8 R9)
    task automatic rev_xfer(input logic [7:0] b, input logic tag);
        bit got;
        for (int i = 0; i < 200 && host_ack; i++) @(negedge clk);
        pd_i = b; periph_ack = tag; periph_clk = 1'b0;
        for (int i = 0; i < 200 && !host_ack; i++) @(negedge clk);
        chk("R8 host ack raised", host_ack, 1'b1);
        periph_clk = 1'b1;
        got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            if (rev_valid) begin
                got = 1;
                chk("R9 byte", rev_byte, b);
                chk("R8 tag", rev_is_data, tag);
            end
        end
        chk("R9 delivered", got, 1'b1);
        @(negedge clk);
        chk("R9 pulse one cycle", rev_valid, 1'b0);
        chk("R9 host ack low", host_ack, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        bit seen_off, got_err, early;
        rst_n = 1'b0; cfg_timeout = 16'd200; rev_mode = 1'b0; fwd_valid = 1'b0;
        fwd_byte = '0; fwd_is_data = 1'b0; periph_ack = 1'b0; periph_clk = 1'b1;
        ack_rev_n = 1'b1; periph_req_n = 1'b1; xflag = 1'b0; pd_i = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobe", host_clk, 1'b1);
        chk("R1 ack", host_ack, 1'b1);
        chk("R1 active", active, 1'b0);
        chk("R1 req", rev_req_n, 1'b1);
        chk("R1 oe", pd_oe, 1'b1);
        chk("R1 ready", fwd_ready, 1'b1);
        chk("R1 rvalid", rev_valid, 1'b0);
        chk("R1 err", err, 1'b0);

        foreach (FWD_VEC[k]) fwd_xfer(FWD_VEC[k][7:0], FWD_VEC[k][8]);

        // R13 status lines
        periph_req_n = 1'b0; xflag = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 req", periph_req, 1'b1);
        chk("R13 xflag", xflag_s, 1'b1);
        periph_req_n = 1'b1; xflag = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 req off", periph_req, 1'b0);

        // R6 turnaround and R7 grant gating
        cfg_timeout = 16'd100;
        rev_mode = 1'b1;
        seen_off = 0; early = 0;
        for (int i = 0; i < 50 && rev_req_n; i++) begin
            @(negedge clk);
            if (!pd_oe && rev_req_n) seen_off = 1;
        end
        chk("R6 released before request", seen_off, 1'b1);
        chk("R6 oe low with request", pd_oe, 1'b0);
        chk("R5 active in reverse", active, 1'b1);
        chk("R4 no ready in reverse", fwd_ready, 1'b0);
        pd_i = 8'h5A; periph_ack = 1'b1; periph_clk = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (host_ack || rev_valid) early = 1;
        end
        chk("R7 nothing before grant", early, 1'b0);
        ack_rev_n = 1'b0;
        for (int i = 0; i < 200 && !host_ack; i++) @(negedge clk);
        chk("R8 ack after grant", host_ack, 1'b1);
        periph_clk = 1'b1;
        for (int i = 0; i < 200 && !rev_valid; i++) @(negedge clk);
        chk("R7 byte after grant", rev_byte, 8'h5A);
        chk("R8 data tag", rev_is_data, 1'b1);

        rev_xfer(8'hC3, 1'b0);
        rev_xfer(8'h96, 1'b1);
        periph_ack = 1'b0;

        // R10 return to forward
        rev_mode = 1'b0;
        for (int i = 0; i < 50 && !rev_req_n; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R10 request lifted", rev_req_n, 1'b1);
        chk("R10 bus still off", pd_oe, 1'b0);
        chk("R10 no ready", fwd_ready, 1'b0);
        ack_rev_n = 1'b1;
        for (int i = 0; i < 50 && !fwd_ready; i++) @(negedge clk);
        chk("R10 forward ready", fwd_ready, 1'b1);
        chk("R10 bus on", pd_oe, 1'b1);
        fwd_xfer(8'h42, 1'b1);

        // R11 timeout on missing ack
        cfg_timeout = 16'd20;
        push_byte(8'h11, 1'b1);
        got_err = 0;
        for (int i = 0; i < 100 && !got_err; i++) begin
            @(negedge clk);
            if (err) got_err = 1;
        end
        chk("R11 err raised", got_err, 1'b1);
        chk("R11 strobe idle", host_clk, 1'b1);
        chk("R11 request idle", rev_req_n, 1'b1);
        chk("R11 active low", active, 1'b0);
        @(negedge clk);
        chk("R11 err one cycle", err, 1'b0);

        // R12 zero limit disables timeout
        cfg_timeout = 16'd0;
        push_byte(8'h22, 1'b0);
        got_err = 0;
        repeat (300) begin
            @(negedge clk);
            if (err) got_err = 1;
        end
        chk("R12 no err", got_err, 1'b0);
        chk("R12 still waiting", host_clk, 1'b0);
        periph_ack = 1'b1;
        for (int i = 0; i < 50 && !host_clk; i++) @(negedge clk);
        periph_ack = 1'b0;
        for (int i = 0; i < 50 && !fwd_ready; i++) @(negedge clk);
        chk("R12 completes", fwd_ready, 1'b1);

        done = 1;
        report();
    end

endmodule